// File: doc/BRIEF.md
# Timed Page-Buffered Flash Programmer

This block sits in front of a byte-addressed non-volatile array and defers programming. Writes issued in normal mode are not applied to the array at once. They land in a page-sized staging buffer, and the block notes which page the latest write addressed. When a fixed number of clock cycles has passed with no further write, the block copies the whole staging buffer into that page of the array, one byte per cycle. Every buffer byte is copied, and bytes nobody wrote still hold the erased value 0xFF. The buffer is then erased again.

Reads go straight to the array. They return what has been committed, not what is waiting in the buffer. While a commit is due or in progress the block raises `busy`. A request made in that window is not accepted, and the caller is expected to hold it. The commit write port is brought out so that the traffic into the array can be observed. With `WIDE_BUS` set, address bit 0 is inverted on the way into the buffer and on array reads, which swaps the two bytes of each 16-bit word.

Top module: `page_commit_flash`

## Requirements
- R1: After reset `busy`, `rd_valid` and `commit_we` are 0, and every array byte reads 0xFF.
- R2: An accepted write stores its byte in the buffer slot `p mod PAGE_BYTES`, where `p` is the physical index. `p` is `(addr mod ARRAY_BYTES)` with bit 0 inverted when `WIDE_BUS=1`.
- R3: The target page base is `p` with its low log2(PAGE_BYTES) bits cleared. The page of the last accepted write decides the base, and address bits at or above log2(ARRAY_BYTES) are ignored.
- R4: Every accepted write restarts the delay count and marks a commit as pending. Writes spaced fewer than `COMMIT_DELAY` cycles apart keep postponing the commit.
- R5: Take the clock edge that accepted the last write as edge 0. `busy` is high after edges `COMMIT_DELAY-1` through `COMMIT_DELAY+PAGE_BYTES-1`. In the cycle after edge `COMMIT_DELAY+i`, `commit_we`=1, `commit_addr`=base+i and `commit_data`=buffer slot i, for i = 0 .. PAGE_BYTES-1.
- R6: Buffer slots not written since the previous commit (or since reset) are committed as 0xFF. The buffer returns to all 0xFF after each commit.
- R7: With no write pending, `busy` and `commit_we` stay 0 and the array does not change.
- R8: A read accepted at an edge gives `rd_valid`=1 and `rd_data`=array[p] after that edge, with `p` formed as in R2.
- R9: While `busy` is high, read and write requests are not accepted. `rd_valid` stays 0 after that edge, and a refused write does not reach the buffer.
- R10: A read of a byte whose new value is still in the buffer returns the value last committed to the array.
- R11: A commit keeps `commit_we` high for exactly PAGE_BYTES consecutive cycles, with `commit_addr` rising by one each cycle. `busy` falls right after the last copy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Read byte, valid with rd_valid |
| rd_valid | output | 1 | Read result present this cycle |
| busy | output | 1 | Commit due or in progress; requests are refused |
| commit_we | output | 1 | Array write strobe of the commit copy |
| commit_addr | output | log2(ARRAY_BYTES) | Array index being programmed |
| commit_data | output | 8 | Byte being programmed |

## Verification
Suppose the delay counter restarts wrongly or misses a restart. `busy` then rises on the wrong cycle, and the bench sees this within `COMMIT_DELAY` cycles of the last write, because it checks `busy` on every cycle of each commit window. A wrong buffer slot, a wrong page base, or a buffer that is not erased after a commit shows up on `commit_addr`/`commit_data` in the very copy cycle concerned. The same faults appear again when the page is read back. A stall leak shows as `rd_valid` one cycle after a refused request. A refused write that leaks into the buffer shows as a non-0xFF byte in the next commit.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t ERASED = 8'hFF;
  typedef enum logic {ST_IDLE, ST_COPY} copy_st_e;
endpackage

// File: rtl/pcf_timer.sv
module pcf_timer #(
  parameter int DELAY = 10690
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic disarm,
  output logic pending,
  output logic due
);
  localparam int CNT_W = $clog2(DELAY + 1);

  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (arm) begin
      pend_d = 1'b1;
      cnt_d  = '0;
    end else if (disarm) begin
      pend_d = 1'b0;
      cnt_d  = '0;
    end else if (pend_q) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pending = pend_q;
  assign due     = pend_q && (cnt_q == CNT_W'(DELAY - 1));
endmodule

// File: rtl/pcf_page_buf.sv
module pcf_page_buf
  import pcf_pkg::*;
#(
  parameter int PAGE_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [$clog2(PAGE_BYTES)-1:0] widx,
  input  byte_t                         wdata,
  input  logic                          fill,
  input  logic [$clog2(PAGE_BYTES)-1:0] ridx,
  output byte_t                         rdata
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  byte_t slot_q [PAGE_BYTES];

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic  en;
    byte_t nxt;
    always_comb begin
      en  = fill || (we && (widx == OFF_W'(i)));
      nxt = fill ? ERASED : wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  slot_q[i] <= ERASED;
      else if (en) slot_q[i] <= nxt;
    end
  end

  assign rdata = slot_q[ridx];

  p_no_fill_and_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill && we));
endmodule

// File: rtl/pcf_store.sv
module pcf_store
  import pcf_pkg::*;
#(
  parameter int BYTES = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(BYTES)-1:0] waddr,
  input  byte_t                    wdata,
  input  logic                     re,
  input  logic [$clog2(BYTES)-1:0] raddr,
  output byte_t                    rdata,
  output logic                     rvalid
);
  localparam int IDX_W = $clog2(BYTES);

  byte_t cell_q [BYTES];

  for (genvar i = 0; i < BYTES; i++) begin : g_cell
    logic en;
    assign en = we && (waddr == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cell_q[i] <= ERASED;
      else if (en) cell_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= cell_q[raddr];
    end
  end
endmodule

// File: rtl/page_commit_flash.sv
module page_commit_flash
  import pcf_pkg::*;
#(
  parameter int ARRAY_BYTES  = 512,
  parameter int PAGE_BYTES   = 64,
  parameter int ADDR_W       = 16,
  parameter int COMMIT_DELAY = 10690,
  parameter bit WIDE_BUS     = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [7:0]                     wr_data,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [7:0]                     rd_data,
  output logic                           rd_valid,
  output logic                           busy,
  output logic                           commit_we,
  output logic [$clog2(ARRAY_BYTES)-1:0] commit_addr,
  output logic [7:0]                     commit_data
);
  localparam int IDX_W = $clog2(ARRAY_BYTES);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = IDX_W - OFF_W;

  copy_st_e         st_q, st_d;
  logic [OFF_W-1:0] idx_q, idx_d;
  logic [PG_W-1:0]  page_q, page_d;
  logic             due, pending, wr_acc, rd_acc, last_copy, fill;
  logic [IDX_W-1:0] wr_phys, rd_phys;
  byte_t            buf_rd;

  // physical index: optional byte swap within each word
  if (WIDE_BUS) begin : g_swap
    assign wr_phys = wr_addr[IDX_W-1:0] ^ IDX_W'(1);
    assign rd_phys = rd_addr[IDX_W-1:0] ^ IDX_W'(1);
  end else begin : g_flat
    assign wr_phys = wr_addr[IDX_W-1:0];
    assign rd_phys = rd_addr[IDX_W-1:0];
  end

  assign busy      = due || (st_q == ST_COPY);
  assign wr_acc    = wr_en && !busy;
  assign rd_acc    = rd_en && !busy;
  assign last_copy = (st_q == ST_COPY) && (idx_q == OFF_W'(PAGE_BYTES - 1));
  assign fill      = last_copy;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    page_d = page_q;
    if (wr_acc) page_d = wr_phys[IDX_W-1:OFF_W];
    case (st_q)
      ST_IDLE: if (due) begin
        st_d  = ST_COPY;
        idx_d = '0;
      end
      ST_COPY: begin
        idx_d = idx_q + OFF_W'(1);
        if (last_copy) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      page_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      page_q <= page_d;
    end
  end

  pcf_timer #(.DELAY(COMMIT_DELAY)) i_timer (
    .clk(clk), .rst_n(rst_n), .arm(wr_acc), .disarm(due),
    .pending(pending), .due(due)
  );

  pcf_page_buf #(.PAGE_BYTES(PAGE_BYTES)) i_buf (
    .clk(clk), .rst_n(rst_n), .we(wr_acc), .widx(wr_phys[OFF_W-1:0]),
    .wdata(wr_data), .fill(fill), .ridx(idx_q), .rdata(buf_rd)
  );

  assign commit_we   = (st_q == ST_COPY);
  assign commit_addr = {page_q, idx_q};
  assign commit_data = buf_rd;

  pcf_store #(.BYTES(ARRAY_BYTES)) i_store (
    .clk(clk), .rst_n(rst_n), .we(commit_we), .waddr(commit_addr),
    .wdata(commit_data), .re(rd_acc), .raddr(rd_phys),
    .rdata(rd_data), .rvalid(rd_valid)
  );

  p_rd_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy) |=> rd_valid);
  p_stall_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rd_valid);
  p_commit_after_due_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_we) |-> $past(due));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !busy) |=> !commit_we);
  p_copy_contig_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_we && !last_copy) |=> (commit_we && (commit_addr == $past(commit_addr) + 1'b1)));
  p_copy_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    last_copy |=> !busy);
endmodule

// File: tb/test_page_commit_flash.sv
module test_page_commit_flash;
  localparam int A  = 64;
  localparam int P  = 8;
  localparam int T  = 20;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data, commit_data;
  logic          rd_valid, busy, commit_we;
  logic [5:0]    commit_addr;

  always #4 clk = ~clk;

  page_commit_flash #(.ARRAY_BYTES(A), .PAGE_BYTES(P), .ADDR_W(AW),
    .COMMIT_DELAY(T), .WIDE_BUS(1'b1)) i_page_commit_flash (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .commit_we(commit_we), .commit_addr(commit_addr),
    .commit_data(commit_data));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int mem_m [A];
  int buf_m [P];
  int base_m = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int phys(int a);
    return (a % A) ^ 1;
  endfunction

  task automatic do_write(int a, int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    buf_m[phys(a) % P] = d;
    base_m = phys(a) & ~(P - 1);
  endtask

  task automatic do_read(int a, string req);
    rd_en = 1'b1; rd_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid == 1'b1, req, "rd_valid", int'(rd_valid), 1);
    chk(rd_data == 8'(mem_m[phys(a)]), req, "rd_data", int'(rd_data), mem_m[phys(a)]);
  endtask

  // starts at the negedge right after the last write's accepting edge
  task automatic commit(bit inject, int ia);
    for (int k = 0; k <= T + P; k++) begin
      if (k > 0) @(negedge clk);
      if (inject && k == T + 3) begin
        chk(rd_valid == 1'b0, "R9", "rd_valid while busy", int'(rd_valid), 0);
        wr_en = 1'b0; rd_en = 1'b0;
      end
      chk(busy == (k >= T - 1 && k <= T + P - 1), "R5", "busy", int'(busy),
          int'(k >= T - 1 && k <= T + P - 1));
      if (k >= T && k < T + P) begin
        chk(commit_we == 1'b1, "R11", "commit_we", int'(commit_we), 1);
        chk(int'(commit_addr) == base_m + k - T, "R3", "commit_addr",
            int'(commit_addr), base_m + k - T);
        chk(int'(commit_data) == buf_m[k - T], "R6", "commit_data",
            int'(commit_data), buf_m[k - T]);
      end else begin
        chk(commit_we == 1'b0, "R11", "commit_we idle", int'(commit_we), 0);
      end
      if (inject && k == T + 2) begin
        wr_en = 1'b1; wr_addr = AW'(ia); wr_data = 8'h3C;
        rd_en = 1'b1; rd_addr = AW'(ia);
      end
    end
    for (int i = 0; i < P; i++) begin
      mem_m[base_m + i] = buf_m[i];
      buf_m[i] = 'hFF;
    end
  endtask

  task automatic read_page(int pg, string req);
    for (int o = 0; o < P; o++) do_read(pg * P + o, req);
  endtask

  initial begin
    for (int i = 0; i < A; i++) mem_m[i] = 'hFF;
    for (int i = 0; i < P; i++) buf_m[i] = 'hFF;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
    chk(commit_we == 1'b0, "R1", "commit_we after reset", int'(commit_we), 0);
    for (int a = 0; a < A; a++) do_read(a, "R1");

    // every page, varied fill patterns; page 0 gets a single byte (R2, R6)
    for (int pg = 0; pg < A / P; pg++) begin
      if (pg == 0) do_write(3, 'h5A);
      else
        for (int o = 0; o < P; o++)
          if ((o + pg) % 3 != 0) do_write(pg * P + o, (pg * 37 + o * 11 + 3) & 'hFF);
      commit(1'b0, 0);
      read_page(pg, "R8");
    end

    // deferral: pending bytes are not yet readable (R10)
    do_write(P + 2, 'hC1);
    do_write(P + 5, 'hC2);
    do_read(P + 2, "R10");
    do_write(P + 6, 'hC3);
    commit(1'b0, 0);
    read_page(1, "R6");

    // aliased high address bits and last-page-wins (R3)
    do_write(A + 2 * P + 1, 'h11);
    do_write(5 * P + 4, 'h22);
    commit(1'b0, 0);
    read_page(5, "R3");
    read_page(2, "R3");

    // restarts postpone the commit (R4)
    do_write(3 * P, 'hA0);
    for (int n = 0; n < T - 3; n++) begin
      @(negedge clk);
      chk(busy == 1'b0, "R4", "busy before restart", int'(busy), 0);
    end
    do_write(3 * P + 1, 'hA1);
    for (int n = 0; n < T - 2; n++) begin
      @(negedge clk);
      chk(busy == 1'b0, "R4", "busy before restart", int'(busy), 0);
    end
    do_write(3 * P + 2, 'hA2);
    commit(1'b0, 0);
    read_page(3, "R4");

    // refused requests while busy (R9)
    do_write(6 * P, 'h77);
    commit(1'b1, 6 * P + 5);
    do_write(6 * P + 1, 'h78);
    commit(1'b0, 0);
    read_page(6, "R9");

    // nothing pending: quiet (R7)
    for (int n = 0; n < 3 * T; n++) begin
      @(negedge clk);
      chk(busy == 1'b0 && commit_we == 1'b0, "R7", "busy|commit_we idle",
          int'(busy | commit_we), 0);
    end
    for (int pg = 0; pg < A / P; pg++) read_page(pg, "R7");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule